// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block sits above a bus cycle controller and drives the machine cycles of each instruction, one after another. Every instruction begins with an opcode fetch at the program counter. The fetched byte is captured in a data register. In the following cycle, the decode state that completes the fetch, the byte is copied into the instruction register and classified. Any opcode other than the direct store is treated as a single-byte no-operation and completes in that decode cycle. The direct store reads two operand bytes at the next program counter addresses, low byte first, then writes the accumulator to the 16-bit address built from them.

The bus side is a request/done handshake. The sequencer holds `bus_req` high with a kind code and an address until the controller returns a one-cycle `bus_done`, which carries the read byte on `bus_rdata`. A one-cycle `instr_done` pulse marks the end of every instruction.

Top module: `mcyc_sequencer`

## Requirements
- R1: While reset is asserted and right after its release, the program counter equals RESET_PC and the instruction and operand address registers are zero. An opcode fetch request (kind 2'b00) at RESET_PC is presented, and `instr_done` is low.
- R2: Each machine cycle is a request held with an unchanged kind and address until the cycle in which `bus_done` is high. Kind codes are 2'b00 for an opcode fetch, 2'b01 for a memory read and 2'b10 for a memory write.
- R3: The program counter increases by exactly one when an opcode or operand read completes. It does not change when a write completes.
- R4: After an opcode fetch completes, there is one decode cycle with `bus_req` low. At its end the fetched byte is in the instruction register.
- R5: Any opcode other than STORE_OP uses exactly one machine cycle. `instr_done` is high in its decode cycle, and the next opcode fetch is requested at the following address.
- R6: Opcode STORE_OP uses four machine cycles in this order: a fetch at P, a read at P+1, a read at P+2, and a write of `acc_in` to address {byte at P+2, byte at P+1}.
- R7: The first operand read loads bits 7:0 of the operand address register and the second loads bits 15:8.
- R8: `instr_done` is a single-cycle pulse, raised once per instruction. For a store it is raised in the cycle in which the write completes.
- R9: An asynchronous reset in the middle of an instruction abandons it, and a new opcode fetch at RESET_PC follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Machine cycle request to the bus controller |
| bus_kind | output | 2 | Cycle kind: 00 fetch, 01 read, 10 write |
| bus_addr | output | 16 | Address of the requested cycle |
| bus_wdata | output | 8 | Write data (accumulator) |
| bus_done | input | 1 | One-cycle completion from the bus controller |
| bus_rdata | input | 8 | Read byte, valid with bus_done |
| acc_in | input | 8 | Accumulator value |
| pc_out | output | 16 | Program counter |
| ir_out | output | 8 | Instruction register |
| opaddr_out | output | 16 | Operand address register |
| instr_done | output | 1 | One-cycle instruction-complete pulse |

## Verification
The request outputs are combinational from the state, so a new request is visible in the same cycle the state is entered. The program counter and operand halves change on the edge that consumes `bus_done`. The instruction register changes one edge later, at the end of the decode cycle. `instr_done` is visible in the decode cycle for single-byte opcodes and in the `bus_done` cycle of the store write. The bench drives `bus_done` at a falling edge and samples 1 ns later for same-cycle results. It checks the registers one falling edge after the instruction finishes, which is after the edge that loads the instruction register. The controller latency is varied from zero to three cycles per vector so that the held request is exercised.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_RD_LO  = 3'd2,
    ST_RD_HI  = 3'd3,
    ST_WRITE  = 3'd4
  } seq_state_t;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;
endpackage

// File: rtl/mcyc_rst_sync.sv
module mcyc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  STORE_OP = 8'h32
) (
  input  logic [DATA_W-1:0] opcode,
  output logic              is_store
);
  always_comb begin
    is_store = (opcode == DATA_W'(STORE_OP));
  end
endmodule

// File: rtl/mcyc_fsm.sv
module mcyc_fsm
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_done,
  input  logic       is_store,
  output logic       bus_req,
  output logic [1:0] bus_kind,
  output logic       instr_done,
  output logic       ld_dr,
  output logic       ld_ir,
  output logic       ld_lo,
  output logic       ld_hi,
  output logic       pc_inc
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  if (bus_done) state_d = ST_DECODE;
      ST_DECODE: state_d = is_store ? ST_RD_LO : ST_FETCH;
      ST_RD_LO:  if (bus_done) state_d = ST_RD_HI;
      ST_RD_HI:  if (bus_done) state_d = ST_WRITE;
      ST_WRITE:  if (bus_done) state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  always_comb begin
    bus_req  = (state_q != ST_DECODE);
    bus_kind = KIND_FETCH;
    if (state_q == ST_RD_LO || state_q == ST_RD_HI) bus_kind = KIND_READ;
    if (state_q == ST_WRITE) bus_kind = KIND_WRITE;
    ld_dr      = bus_done && (state_q == ST_FETCH);
    ld_ir      = (state_q == ST_DECODE);
    ld_lo      = bus_done && (state_q == ST_RD_LO);
    ld_hi      = bus_done && (state_q == ST_RD_HI);
    pc_inc     = bus_done && bus_req && (state_q != ST_WRITE);
    instr_done = ((state_q == ST_DECODE) && !is_store) ||
                 ((state_q == ST_WRITE) && bus_done);
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_kind)));

  assert_decode_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE) |=> (state_q == ST_FETCH || state_q == ST_RD_LO));

  assert_write_after_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_HI && bus_done) |=> (bus_kind == KIND_WRITE));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);
endmodule

// File: rtl/mcyc_datapath.sv
module mcyc_datapath
  import mcyc_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [15:0]     RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_dr,
  input  logic              ld_ir,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              pc_inc,
  input  logic              bus_req,
  input  logic              bus_done,
  input  logic [1:0]        bus_kind,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] acc_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] opaddr
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] pc_d, opaddr_d;
  logic [DATA_W-1:0] dr_d, ir_d;

  always_comb begin
    pc_d     = pc;
    dr_d     = dr;
    ir_d     = ir;
    opaddr_d = opaddr;
    if (pc_inc) pc_d = pc + ADDR_W'(1);
    if (ld_dr)  dr_d = bus_rdata;
    if (ld_ir)  ir_d = dr;
    if (ld_lo)  opaddr_d[HALF-1:0]      = HALF'(bus_rdata);
    if (ld_hi)  opaddr_d[ADDR_W-1:HALF] = HALF'(bus_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= ADDR_W'(RESET_PC);
      dr     <= '0;
      ir     <= '0;
      opaddr <= '0;
    end else begin
      pc     <= pc_d;
      dr     <= dr_d;
      ir     <= ir_d;
      opaddr <= opaddr_d;
    end
  end

  always_comb begin
    bus_addr  = (bus_kind == KIND_WRITE) ? opaddr : pc;
    bus_wdata = acc_in;
  end

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> $stable(bus_addr));

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_kind != KIND_WRITE) |=> (pc == $past(pc) + ADDR_W'(1)));

  assert_pc_hold_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_kind == KIND_WRITE) |=> $stable(pc));
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [7:0]  STORE_OP = 8'h32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic [1:0]        bus_kind,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] acc_in,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] ir_out,
  output logic [ADDR_W-1:0] opaddr_out,
  output logic              instr_done
);
  logic srst_n;
  logic is_store;
  logic ld_dr, ld_ir, ld_lo, ld_hi, pc_inc;
  logic [DATA_W-1:0] dr;

  mcyc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mcyc_decode #(.DATA_W(DATA_W), .STORE_OP(STORE_OP)) u_dec (
    .opcode   (dr),
    .is_store (is_store)
  );

  mcyc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .bus_done   (bus_done),
    .is_store   (is_store),
    .bus_req    (bus_req),
    .bus_kind   (bus_kind),
    .instr_done (instr_done),
    .ld_dr      (ld_dr),
    .ld_ir      (ld_ir),
    .ld_lo      (ld_lo),
    .ld_hi      (ld_hi),
    .pc_inc     (pc_inc)
  );

  mcyc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst_n     (srst_n),
    .ld_dr     (ld_dr),
    .ld_ir     (ld_ir),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .pc_inc    (pc_inc),
    .bus_req   (bus_req),
    .bus_done  (bus_done),
    .bus_kind  (bus_kind),
    .bus_rdata (bus_rdata),
    .acc_in    (acc_in),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pc        (pc_out),
    .dr        (dr),
    .ir        (ir_out),
    .opaddr    (opaddr_out)
  );
endmodule

// File: tb/mcyc_sequencer_bench.sv
module mcyc_sequencer_bench;
  localparam logic [7:0] ST_OP = 8'h32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req, bus_done = 1'b0, instr_done;
  logic [1:0]  bus_kind;
  logic [15:0] bus_addr, pc_out, opaddr_out;
  logic [7:0]  bus_wdata, bus_rdata = 8'h00, acc_in = 8'h00, ir_out;

  int checks = 0;
  int failures = 0;

  logic [7:0]  mem [0:255];
  logic [1:0]  k_log [0:7];
  logic [15:0] a_log [0:7];
  logic [7:0]  w_log [0:7];
  int          stable_err;

  always #5 clk = ~clk;

  mcyc_sequencer u_mcyc_sequencer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .acc_in(acc_in), .pc_out(pc_out), .ir_out(ir_out),
    .opaddr_out(opaddr_out), .instr_done(instr_done)
  );

  // fields: opcode, low byte, high byte, accumulator, controller latency
  localparam logic [39:0] VEC [0:6] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'd0},
    {8'h32, 8'h05, 8'h21, 8'h41, 8'd1},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'd2},
    {8'h32, 8'hFF, 8'hFF, 8'hA5, 8'd3},
    {8'h32, 8'h00, 8'h00, 8'h00, 8'd0},
    {8'h3C, 8'h00, 8'h00, 8'h00, 8'd1},
    {8'h32, 8'h34, 8'h12, 8'h7E, 8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_instr(input int lat, output int nacc, output logic got_done);
    int wc;
    int cyc;
    logic [15:0] first_a;
    wc = 0; cyc = 0; nacc = 0; got_done = 1'b0; first_a = '0;
    while (!got_done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (bus_done) begin
        bus_done = 1'b0;
      end else if (bus_req) begin
        if (wc == 0) first_a = bus_addr;
        if (wc >= lat) begin
          if (bus_addr !== first_a) stable_err++;
          if (nacc < 8) begin
            k_log[nacc] = bus_kind;
            a_log[nacc] = bus_addr;
            w_log[nacc] = bus_wdata;
          end
          bus_rdata = mem[bus_addr[7:0]];
          bus_done  = 1'b1;
          nacc++;
          wc = 0;
        end else begin
          wc++;
        end
      end
      #1;
      if (instr_done) got_done = 1'b1;
    end
    if (cyc >= 200) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=instr_done");
    end
    @(negedge clk);
    bus_done = 1'b0;
    #1;
  endtask

  initial begin
    int p;
    int nacc;
    logic gd;
    logic [15:0] exp_pc;

    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    p = 0;
    for (int v = 0; v < 7; v++) begin
      mem[p] = VEC[v][39:32];
      if (VEC[v][39:32] == ST_OP) begin
        mem[p+1] = VEC[v][31:24];
        mem[p+2] = VEC[v][23:16];
        p += 3;
      end else begin
        p += 1;
      end
    end
    stable_err = 0;

    // R1 reset state while held in reset
    repeat (2) @(negedge clk);
    #1;
    chk("R1 pc", 32'(pc_out), 32'h0);
    chk("R1 ir", 32'(ir_out), 32'h0);
    chk("R1 opaddr", 32'(opaddr_out), 32'h0);
    chk("R1 done low", 32'(instr_done), 32'h0);
    chk("R1 fetch req", {29'b0, bus_req, bus_kind}, {29'b0, 1'b1, 2'b00});
    chk("R1 fetch addr", 32'(bus_addr), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 after release", {15'b0, bus_req, pc_out}, {15'b0, 1'b1, 16'h0000});

    exp_pc = 16'h0000;
    for (int v = 0; v < 7; v++) begin
      logic [7:0] op, lo, hi, ac;
      logic st;
      op = VEC[v][39:32]; lo = VEC[v][31:24]; hi = VEC[v][23:16];
      ac = VEC[v][15:8];
      st = (op == ST_OP);
      acc_in = ac;
      run_instr(int'(VEC[v][7:0]), nacc, gd);
      chk("R8 instr_done seen", 32'(gd), 32'h1);
      chk("R2 fetch kind", 32'(k_log[0]), 32'h0);
      chk("R2 fetch addr", 32'(a_log[0]), 32'(exp_pc));
      chk("R4 ir loaded", 32'(ir_out), 32'(op));
      chk("R8 done dropped", 32'(instr_done), 32'h0);
      if (st) begin
        chk("R6 cycle count", 32'(nacc), 32'd4);
        chk("R6 rd lo kind", 32'(k_log[1]), 32'h1);
        chk("R6 rd lo addr", 32'(a_log[1]), 32'(exp_pc + 16'd1));
        chk("R6 rd hi kind", 32'(k_log[2]), 32'h1);
        chk("R6 rd hi addr", 32'(a_log[2]), 32'(exp_pc + 16'd2));
        chk("R6 wr kind", 32'(k_log[3]), 32'h2);
        chk("R6 wr addr", 32'(a_log[3]), 32'({hi, lo}));
        chk("R6 wr data", 32'(w_log[3]), 32'(ac));
        chk("R7 opaddr", 32'(opaddr_out), 32'({hi, lo}));
        exp_pc = exp_pc + 16'd3;
      end else begin
        chk("R5 cycle count", 32'(nacc), 32'd1);
        exp_pc = exp_pc + 16'd1;
      end
      chk("R3 pc", 32'(pc_out), 32'(exp_pc));
      chk("R5 next fetch", {29'b0, bus_req, bus_kind}, {29'b0, 1'b1, 2'b00});
    end
    chk("R2 held addr", 32'(stable_err), 32'h0);

    // R9 reset in the middle of a store: fetch, low read, then stop in high read
    mem[exp_pc[7:0]]          = ST_OP;
    mem[exp_pc[7:0] + 8'd1]   = 8'h11;
    mem[exp_pc[7:0] + 8'd2]   = 8'h22;
    for (int n = 0; n < 2; n++) begin
      while (!bus_req) @(negedge clk);
      bus_rdata = mem[bus_addr[7:0]];
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      @(negedge clk);
    end
    #1;
    chk("R7 low half loaded", 32'(opaddr_out[7:0]), 32'h11);
    chk("R9 in high read", {30'b0, bus_kind}, 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R9 pc reset", 32'(pc_out), 32'h0);
    chk("R9 opaddr reset", 32'(opaddr_out), 32'h0);
    chk("R9 fetch at reset pc", {13'b0, bus_req, bus_kind, bus_addr[15:0]}, {13'b0, 1'b1, 2'b00, 16'h0000});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    acc_in = 8'h00;
    run_instr(0, nacc, gd);
    chk("R9 restart fetch addr", 32'(a_log[0]), 32'h0);
    chk("R9 restart pc", 32'(pc_out), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule